// File: doc/BRIEF.md
# Distributed CAS-before-RAS Refresh Scheduler

This block keeps a DRAM array refreshed without an external row counter. The array needs 2048 refresh cycles per retention period: 32 ms on standard parts and 128 ms on low-power parts. The block spreads them evenly, so a free-running interval timer posts one refresh request every 15.6 µs. Requests that arrive while the memory is busy are counted as pending. When the array is free, the block drives the strobe pins through a CAS-before-RAS cycle, and the device supplies the row address from its own internal counter.

After reset the block first waits a long power-up pause. It then issues a burst of CBR cycles and only then raises `init_done`. From then on it arbitrates between the access sequencer and its own refresh work:

- Access requests are granted through a one-cycle `acc_gnt`.
- Once granted, an access owns the array until the sequencer pulses `acc_done`.
- If deferred refreshes pile up past a threshold, `urgent` rises and new accesses are held off until the backlog drains.

All durations are parameters counted in clock cycles. The defaults assume a 10 ns clock: a 1560-cycle interval and a 20000-cycle pause. The timing parameters default to 1 cycle of CAS lead, 6 cycles of RAS low and 4 cycles of precharge.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While reset is held, `ras_n`, `cas_n` and `we_n` are high, `init_done` is low, `pending` is 0 and `acc_gnt` is low.
- R2: After reset is released, `cas_n` stays high for at least `PAUSE_CYC` cycles.
- R3: The power-up sequence works as follows:
  - After the pause, exactly `INIT_CBR` CBR cycles are issued, and then `init_done` rises.
  - Once high, `init_done` stays high until the next reset.
- R4: While `init_done` is low, `acc_req` is ignored and `acc_gnt` stays low. A request still held when `init_done` rises is granted in that same cycle.
- R5: Each refresh cycle has the following waveform:
  - `cas_n` falls and stays low for `CSR_CYC` cycles before `ras_n` falls.
  - `ras_n` then stays low for exactly `RAS_CYC` cycles, and `cas_n` is low throughout.
  - `cas_n` rises in the same cycle as `ras_n`.
  - `we_n` is high.
- R6: After a refresh, both strobes stay high for at least `RP_CYC` cycles before `cas_n` falls again.
- R7: The interval timer behaves as follows:
  - It is held until `init_done` rises, so `pending` is 0 at that moment.
  - After that it posts one request every `INTERVAL` cycles.
  - With no accesses, the rate of refresh cycles matches the rate of posted requests.
- R8: `pending` behaves as follows:
  - It rises by one for each posted request that cannot be served.
  - It never changes by more than one per cycle.
  - It saturates at `PEND_MAX`.
- R9: No refresh starts between `acc_gnt` and `acc_done`. A pending refresh starts at most two cycles after `acc_done`, unless a new access is granted first.
- R10: The urgent condition behaves as follows:
  - `urgent` is high exactly when `pending` exceeds `URG_TH`.
  - `acc_gnt` is never high while `urgent` or `ref_busy` is high.
  - Backlog refreshes run until `pending` is at or below `URG_TH`.
- R11: When `urgent` is low and the block is idle, `acc_req` wins over a pending refresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_req | input | 1 | Sequencer asks for the array |
| acc_done | input | 1 | One-cycle pulse ending a granted access |
| acc_gnt | output | 1 | Access granted; the array belongs to the sequencer from the next cycle |
| init_done | output | 1 | Power-up pause and initial refresh burst finished |
| urgent | output | 1 | Refresh backlog above threshold; accesses held off |
| ref_busy | output | 1 | Block owns the strobes (refresh or its precharge) |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high during refresh |
| pending | output | $clog2(PEND_MAX+1) | Count of deferred refresh requests |

## Verification
The bench builds the block with the following parameters:

| Parameter | Value |
|-----------|-------|
| `INTERVAL` | 40 |
| `PAUSE_CYC` | 50 |
| `INIT_CBR` | 8 |
| `PEND_MAX` | 8 |
| `URG_TH` | 3 |
| `CSR_CYC` | 2 |
| `RAS_CYC` | 3 |
| `RP_CYC` | 2 |

With the short interval and pause, the whole init burst, a full saturation of the pending counter and the urgent drain all fit in a few hundred cycles. Two hundred randomly sized accesses then run in a few thousand more. A two-cycle CAS lead and a three-cycle RAS width make off-by-one errors in each waveform phase visible.

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched #(
  parameter int INTERVAL  = 1560,
  parameter int PAUSE_CYC = 20000,
  parameter int INIT_CBR  = 8,
  parameter int PEND_MAX  = 8,
  parameter int URG_TH    = 4,
  parameter int CSR_CYC   = 1,
  parameter int RAS_CYC   = 6,
  parameter int RP_CYC    = 4,
  localparam int PW = $clog2(PEND_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_req,
  input  logic          acc_done,
  output logic          acc_gnt,
  output logic          init_done,
  output logic          urgent,
  output logic          ref_busy,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic [PW-1:0] pending
);

  localparam int M1   = (PAUSE_CYC > RAS_CYC) ? PAUSE_CYC : RAS_CYC;
  localparam int M2   = (CSR_CYC > RP_CYC) ? CSR_CYC : RP_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int TW   = $clog2(INTERVAL);
  localparam int IW   = $clog2(INIT_CBR + 1);

  typedef enum logic [2:0] {S_PAUSE, S_IDLE, S_ACC, S_CAS, S_RAS, S_PRE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tcnt;
  logic [IW-1:0] init_left;

  wire tick       = init_done && (tcnt == TW'(INTERVAL - 1));
  wire idle       = (st == S_IDLE);
  wire phase_end  = (cnt == '0);
  wire start_norm = idle && init_done && !acc_gnt && (pending != '0);
  wire start_init = idle && !init_done && (init_left != '0);

  assign urgent   = pending > PW'(URG_TH);
  assign acc_gnt  = idle && init_done && !urgent && acc_req;
  assign ref_busy = (st == S_CAS) || (st == S_RAS) || (st == S_PRE);
  assign ras_n    = (st != S_RAS);
  assign cas_n    = !((st == S_CAS) || (st == S_RAS));
  assign we_n     = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt    <= '0;
      pending <= '0;
    end else begin
      if (init_done) tcnt <= tick ? '0 : tcnt + 1'b1;
      case ({tick, start_norm})
        2'b10:   if (pending != PW'(PEND_MAX)) pending <= pending + 1'b1;
        2'b01:   pending <= pending - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_PAUSE;
      cnt       <= CW'(PAUSE_CYC - 1);
      init_left <= IW'(INIT_CBR);
      init_done <= 1'b0;
    end else begin
      case (st)
        S_PAUSE: if (phase_end) st <= S_IDLE; else cnt <= cnt - 1'b1;
        S_IDLE: begin
          if (acc_gnt) st <= S_ACC;
          else if (start_norm || start_init) begin
            st  <= S_CAS;
            cnt <= CW'(CSR_CYC - 1);
            if (start_init) init_left <= init_left - 1'b1;
          end
        end
        S_ACC: if (acc_done) st <= S_IDLE;
        S_CAS: begin
          if (phase_end) begin
            st  <= S_RAS;
            cnt <= CW'(RAS_CYC - 1);
          end else cnt <= cnt - 1'b1;
        end
        S_RAS: begin
          if (phase_end) begin
            st  <= S_PRE;
            cnt <= CW'(RP_CYC - 1);
          end else cnt <= cnt - 1'b1;
        end
        S_PRE: begin
          if (phase_end) begin
            st <= S_IDLE;
            if (!init_done && init_left == '0) init_done <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module cbr_refresh_sched_chk #(
  parameter int PEND_MAX = 8,
  parameter int RAS_CYC  = 6,
  parameter int RP_CYC   = 4,
  parameter int PW       = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_gnt,
  input logic          init_done,
  input logic          urgent,
  input logic          ref_busy,
  input logic          ras_n,
  input logic          cas_n,
  input logic [PW-1:0] pending
);

  logic [15:0] ras_low, hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_low <= '0;
      hi_run  <= 16'hFFFF;
    end else begin
      ras_low <= !ras_n ? ras_low + 1'b1 : '0;
      hi_run  <= (ras_n && cas_n) ? ((hi_run == 16'hFFFF) ? hi_run : hi_run + 1'b1) : '0;
    end
  end

  a_r5_cas_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));
  a_r5_cas_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n);
  a_r5_ras_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> ras_low == 16'(RAS_CYC));
  a_r6_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> hi_run >= 16'(RP_CYC));
  a_r3_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  a_r4_no_early_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !acc_gnt);
  a_r10_grant_gated: assert property (@(posedge clk) disable iff (!rst_n)
    acc_gnt |-> (!urgent && !ref_busy));
  a_r8_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pending <= PW'(PEND_MAX));
  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == $past(pending)) || (pending == $past(pending) + 1'b1) ||
    (pending + 1'b1 == $past(pending)));

endmodule

bind cbr_refresh_sched cbr_refresh_sched_chk #(
  .PEND_MAX(PEND_MAX), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC), .PW(PW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_gnt(acc_gnt), .init_done(init_done),
  .urgent(urgent), .ref_busy(ref_busy), .ras_n(ras_n), .cas_n(cas_n),
  .pending(pending)
);

// File: tb/cbr_refresh_sched_bench.sv
module cbr_refresh_sched_bench;
  localparam int INTERVAL_C = 40;
  localparam int PAUSE_C    = 50;
  localparam int INIT_C     = 8;
  localparam int PEND_C     = 8;
  localparam int URG_C      = 3;
  localparam int CSR_C      = 2;
  localparam int RAS_C      = 3;
  localparam int RP_C       = 2;
  localparam int PW         = $clog2(PEND_C + 1);

  logic clk = 0;
  always #4 clk = ~clk;

  logic rst_n, acc_req, acc_done;
  logic acc_gnt, init_done, urgent, ref_busy, ras_n, cas_n, we_n;
  logic [PW-1:0] pending;

  cbr_refresh_sched #(
    .INTERVAL(INTERVAL_C), .PAUSE_CYC(PAUSE_C), .INIT_CBR(INIT_C), .PEND_MAX(PEND_C),
    .URG_TH(URG_C), .CSR_CYC(CSR_C), .RAS_CYC(RAS_C), .RP_CYC(RP_C)
  ) u_cbr_refresh_sched (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_done(acc_done), .acc_gnt(acc_gnt),
    .init_done(init_done), .urgent(urgent), .ref_busy(ref_busy), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .pending(pending)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic chk(bit ok, string req, int act, int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic bit in_win(int v, int lo, int hi);
    return (v >= lo) && (v <= hi);
  endfunction

  function automatic int sat_pend(int ticks);
    return (ticks > PEND_C) ? PEND_C : ticks;
  endfunction

  int csr_run, ras_run, gap, ref_count = 0;
  logic pr_ras = 1, pr_cas = 1;
  bit seen_rise = 0, gnt_pre_init = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      csr_run = 0; ras_run = 0; gap = 0; pr_ras = 1; pr_cas = 1; seen_rise = 0;
    end else begin
      if (pr_ras && !ras_n) begin
        ref_count++;
        chk(csr_run == CSR_C, "R5 cas lead", csr_run, CSR_C);
        chk(we_n == 1'b1, "R5 we high", int'(we_n), 1);
      end
      if (!pr_ras && ras_n) begin
        chk(ras_run == RAS_C, "R5 ras width", ras_run, RAS_C);
        chk(cas_n == 1'b1, "R5 cas rises with ras", int'(cas_n), 1);
        seen_rise = 1;
      end
      if (pr_cas && !cas_n && seen_rise) chk(gap >= RP_C, "R6 precharge", gap, RP_C);
      if (!ras_n && cas_n) chk(0, "R5 cas held low", 1, 0);
      if (acc_gnt) begin
        chk(init_done && !urgent && !ref_busy, "R10 grant gating", int'(urgent), 0);
        if (!init_done) gnt_pre_init = 1;
      end
      csr_run = (!cas_n && ras_n) ? csr_run + 1 : 0;
      ras_run = !ras_n ? ras_run + 1 : 0;
      gap     = (ras_n && cas_n) ? gap + 1 : 0;
      pr_ras  = ras_n;
      pr_cas  = cas_n;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic grab();
    acc_req = 1;
    #1;
    while (!acc_gnt) step();
    step();
    acc_req = 0;
  endtask

  task automatic release_acc();
    acc_done = 1;
    step();
    acc_done = 0;
  endtask

  initial begin
    int n, r0, p;
    void'($urandom(32'd1234));
    rst_n = 0; acc_req = 0; acc_done = 0;
    repeat (3) step();
    chk(ras_n && cas_n && we_n, "R1 pins idle in reset", int'(ras_n & cas_n & we_n), 1);
    chk(!init_done, "R1 init_done low", int'(init_done), 0);
    chk(pending == 0, "R1 pending clear", int'(pending), 0);
    chk(!acc_gnt, "R1 no grant", int'(acc_gnt), 0);

    rst_n = 1; acc_req = 1;
    n = 0;
    while (cas_n) begin step(); n++; end
    chk(in_win(n, PAUSE_C, PAUSE_C + 3), "R2 pause length", n, PAUSE_C);
    r0 = ref_count;
    while (!init_done) step();
    chk(ref_count - r0 == INIT_C, "R3 init burst count", ref_count - r0, INIT_C);
    chk(!gnt_pre_init, "R4 request ignored during init", int'(gnt_pre_init), 0);
    chk(acc_gnt == 1'b1, "R4 held request granted at init_done", int'(acc_gnt), 1);
    chk(pending == 0, "R7 timer held during init", int'(pending), 0);
    step(); acc_req = 0;
    release_acc();
    n = 2;
    while (cas_n) begin step(); n++; end
    chk(in_win(n, INTERVAL_C, INTERVAL_C + 2), "R7 first request timing", n, INTERVAL_C + 1);
    while (ref_busy) step();

    grab();
    r0 = ref_count;
    repeat (60) step();
    chk(ref_count == r0, "R9 no refresh during access", ref_count - r0, 0);
    p = int'(pending);
    chk(in_win(p, 1, 2), "R8 deferred ticks counted", p, 1);
    acc_done = 1; acc_req = 1;
    step();
    acc_done = 0;
    chk(acc_gnt && !ref_busy, "R11 access wins over pending refresh", int'(acc_gnt), 1);
    step(); acc_req = 0;
    repeat (4) step();
    release_acc();
    n = 0;
    while (cas_n) begin step(); n++; end
    chk(n <= 2, "R9 refresh after access ends", n, 1);
    while (pending != 0 || ref_busy) step();

    grab();
    repeat (12 * INTERVAL_C) step();
    chk(int'(pending) == sat_pend(12), "R8 saturation", int'(pending), sat_pend(12));
    chk(urgent == 1'b1, "R10 urgent raised", int'(urgent), 1);
    acc_done = 1; acc_req = 1;
    step();
    acc_done = 0;
    r0 = ref_count;
    while (!acc_gnt) step();
    chk(int'(pending) <= URG_C, "R10 grant after backlog drained", int'(pending), URG_C);
    chk(ref_count - r0 >= PEND_C - URG_C, "R10 urgent refreshes first", ref_count - r0, PEND_C - URG_C);
    step(); acc_req = 0;
    release_acc();

    repeat (200) begin
      int idle_gap, len;
      idle_gap = $urandom_range(0, 30);
      len = $urandom_range(1, 70);
      repeat (idle_gap) step();
      grab();
      r0 = ref_count;
      repeat (len) step();
      chk(ref_count == r0, "R9 random access undisturbed", ref_count - r0, 0);
      release_acc();
    end

    while (pending != 0 || ref_busy) step();
    r0 = ref_count;
    repeat (10 * INTERVAL_C) step();
    chk(in_win(ref_count - r0, 9, 11), "R7 refresh rate", ref_count - r0, 10);
    chk(init_done == 1'b1, "R3 init_done sticky", int'(init_done), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R9 actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule